// File: doc/BRIEF.md
# Pad Event Trigger Router

This block turns the receive level of a single pad into an interrupt event and sends it to any combination of four destination lines: a non-maskable line, a system-management line, a system-control (wake) line and a line for the I/O interrupt controller. The pad input is asynchronous. It passes through a synchronizer, and the synchronized level is then qualified by a polarity-inversion bit. A two-bit trigger mode decides whether the qualified level drives the destinations directly, or whether edges produce one-cycle pulses. The mode choices are level, a single edge whose direction comes from the inversion bit, both edges, or off.

Software controls the block through a small register port with two addresses. Address 0 holds the configuration word: trigger mode, inversion, receive disable, a one-hot-per-destination routing field and the transmit drive value. Reading address 0 also returns the current synchronized receive level. Address 1 holds a sticky event status bit, which software clears by writing a one to it. All control and status pins are plain levels. The block has no streaming interface and applies no back-pressure.

Top module: `padevt_router`

## Requirements
- R1: While reset is active, all four destination outputs and the transmit output are 0, the status bit is 0, and address 0 reads 0x0400_0000 (trigger mode field = 2, off; every other field 0; receive level 0).
- R2: The pad input passes two synchronizer flops. A pad change appears in read bit 1 of address 0 after the second rising clock edge, and any event it causes reaches the destination outputs on the third rising edge.
- R3: Trigger field bits 26:25 = 0 selects level mode. Every routed destination is high for as long as the synchronized level XOR the inversion bit (bit 23) is 1.
- R4: Trigger field = 1 selects single-edge mode. With bit 23 clear, each rising input edge produces a one-cycle pulse. With bit 23 set, each falling input edge produces the pulse instead.
- R5: Trigger field = 3 produces a one-cycle pulse for every input transition in either direction.
- R6: Trigger field = 2 produces no destination activity and does not set the status bit.
- R7: Routing bits 17, 18, 19 and 20 enable the non-maskable, system-management, system-control and I/O-interrupt-controller outputs respectively. Any number of these bits may be set together. An output is never active unless its routing bit was set in the cycle that produced the event.
- R8: With the receive-disable bit (bit 9) set, no destination output is asserted and the status bit is never set.
- R9: Bit 0 of address 1 is a sticky status bit. Any event (an edge pulse, or an asserted qualified level in level mode) sets it. Writing 1 to bit 0 of address 1 clears it. If an event and a clear land in the same cycle, the event wins.
- R10: A write to address 0 reloads the edge detector's previous-sample register from the current level and the new inversion bit. A change of mode or polarity on a steady input therefore never produces an event.
- R11: Address 0 reads back the stored fields at their write positions, with bit 1 showing the synchronized receive level. Writes to bit 1 and to all unassigned bits are ignored, and those bits read 0. Bit 0 drives the transmit output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pad_rx_i | input | 1 | Asynchronous receive level from the pad |
| pad_tx_o | output | 1 | Stored transmit drive value |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | Register select: 0 config, 1 status |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i, combinational |
| evt_nmi_o | output | 1 | Non-maskable destination |
| evt_smm_o | output | 1 | System-management destination |
| evt_sysctl_o | output | 1 | System-control (wake) destination |
| evt_intc_o | output | 1 | I/O interrupt controller destination |

## Verification
The bench targets polarity changes applied to a pad that is already held high. A design that does not reload its previous sample on a configuration write would produce a spurious edge pulse and set the status bit. The bench also issues a status clear in the same cycle as an event, where a design that gives the clear priority would lose the event. Receive disable is tested in both-edges mode under heavy input toggling; a design that gated only the outputs and not the status bit would still show status set. Long stretches of random input and configuration changes check that a single-edge design never holds a pulse for two cycles and never sends an event to a destination whose routing bit is clear.

// File: rtl/padevt_pkg.sv
package padevt_pkg;
  localparam int CFG_W     = 32;
  localparam int NUM_DEST  = 4;
  localparam int TX_BIT    = 0;
  localparam int RXLVL_BIT = 1;
  localparam int RXDIS_BIT = 9;
  localparam int ROUTE_LSB = 17;
  localparam int INV_BIT   = 23;
  localparam int TRIG_LSB  = 25;
  localparam int STAT_BIT  = 0;

  typedef enum logic [1:0] {
    TRIG_LEVEL = 2'd0,
    TRIG_EDGE  = 2'd1,
    TRIG_OFF   = 2'd2,
    TRIG_BOTH  = 2'd3
  } trig_e;

  typedef struct packed {
    trig_e                trig;
    logic                 inv;
    logic [NUM_DEST-1:0]  route;
    logic                 rx_dis;
    logic                 tx_val;
  } cfg_t;
endpackage

// File: rtl/padevt_sync.sv
module padevt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = sh[STAGES-1];
endmodule

// File: rtl/padevt_regs.sv
module padevt_regs
  import padevt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic              addr_i,
  input  logic [CFG_W-1:0]  wdata_i,
  input  logic              rx_lvl_i,
  input  logic              fire_i,
  output cfg_t              cfg_o,
  output logic              cfg_wr_o,
  output logic              reload_inv_o,
  output logic [CFG_W-1:0]  rdata_o
);
  localparam cfg_t CFG_RST = '{trig: TRIG_OFF, inv: 1'b0, route: '0, rx_dis: 1'b0, tx_val: 1'b0};

  cfg_t cfg_q;
  logic stat_q;
  logic clr_req;

  assign cfg_wr_o     = we_i && (addr_i == 1'b0);
  assign clr_req      = we_i && (addr_i == 1'b1) && wdata_i[STAT_BIT];
  assign reload_inv_o = wdata_i[INV_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
    end else if (cfg_wr_o) begin
      cfg_q.trig   <= trig_e'(wdata_i[TRIG_LSB +: 2]);
      cfg_q.inv    <= wdata_i[INV_BIT];
      cfg_q.route  <= wdata_i[ROUTE_LSB +: NUM_DEST];
      cfg_q.rx_dis <= wdata_i[RXDIS_BIT];
      cfg_q.tx_val <= wdata_i[TX_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (fire_i)  stat_q <= 1'b1;
    else if (clr_req) stat_q <= 1'b0;
  end

  assign cfg_o = cfg_q;

  always_comb begin
    rdata_o = '0;
    if (addr_i == 1'b0) begin
      rdata_o[TX_BIT]                  = cfg_q.tx_val;
      rdata_o[RXLVL_BIT]               = rx_lvl_i;
      rdata_o[RXDIS_BIT]               = cfg_q.rx_dis;
      rdata_o[ROUTE_LSB +: NUM_DEST]   = cfg_q.route;
      rdata_o[INV_BIT]                 = cfg_q.inv;
      rdata_o[TRIG_LSB +: 2]           = cfg_q.trig;
    end else begin
      rdata_o[STAT_BIT]                = stat_q;
    end
  end

  // R9: status stays set unless a clear is requested
  p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_req) |=> stat_q);
  // R9: status only rises after an event from the trigger logic
  p_status_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(fire_i));
  // R9: an event in the same cycle as a clear leaves status set
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (fire_i && clr_req) |=> stat_q);
endmodule

// File: rtl/padevt_trigger.sv
module padevt_trigger
  import padevt_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rx_lvl_i,
  input  cfg_t cfg_i,
  input  logic cfg_wr_i,
  input  logic reload_inv_i,
  output logic fire_o
);
  logic qual;
  logic prev_q;
  logic hit;

  assign qual = rx_lvl_i ^ cfg_i.inv;

  always_comb begin
    unique case (cfg_i.trig)
      TRIG_LEVEL: hit = qual;
      TRIG_EDGE:  hit = qual & ~prev_q;
      TRIG_BOTH:  hit = qual ^ prev_q;
      default:    hit = 1'b0;
    endcase
  end

  assign fire_o = hit & ~cfg_i.rx_dis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        prev_q <= 1'b0;
    else if (cfg_wr_i) prev_q <= rx_lvl_i ^ reload_inv_i;
    else               prev_q <= qual;
  end

  // R4: single-edge events never last two cycles under a steady config
  p_one_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i.trig == TRIG_EDGE && fire_o && !cfg_wr_i) |=> !fire_o);
  // R10: a config write on a steady input gives no edge event
  p_no_false_edge_r10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> (!$stable(rx_lvl_i) || cfg_i.trig == TRIG_LEVEL || !fire_o));
endmodule

// File: rtl/padevt_route.sv
module padevt_route #(
  parameter int NUM_DEST = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fire_i,
  input  logic [NUM_DEST-1:0] route_i,
  output logic [NUM_DEST-1:0] dest_o
);
  generate
    for (genvar i = 0; i < NUM_DEST; i++) begin : g_dest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dest_o[i] <= 1'b0;
        else        dest_o[i] <= fire_i & route_i[i];
      end
    end
  endgenerate
endmodule

// File: rtl/padevt_router.sv
module padevt_router
  import padevt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pad_rx_i,
  output logic              pad_tx_o,
  input  logic              reg_we_i,
  input  logic              reg_addr_i,
  input  logic [CFG_W-1:0]  reg_wdata_i,
  output logic [CFG_W-1:0]  reg_rdata_o,
  output logic              evt_nmi_o,
  output logic              evt_smm_o,
  output logic              evt_sysctl_o,
  output logic              evt_intc_o
);
  logic                rx_lvl;
  logic                fire;
  logic                cfg_wr;
  logic                reload_inv;
  cfg_t                cfg;
  logic [NUM_DEST-1:0] dest;

  padevt_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pad_rx_i), .q_o(rx_lvl)
  );

  padevt_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rx_lvl_i(rx_lvl), .fire_i(fire),
    .cfg_o(cfg), .cfg_wr_o(cfg_wr), .reload_inv_o(reload_inv),
    .rdata_o(reg_rdata_o)
  );

  padevt_trigger u_trig (
    .clk(clk), .rst_n(rst_n), .rx_lvl_i(rx_lvl), .cfg_i(cfg),
    .cfg_wr_i(cfg_wr), .reload_inv_i(reload_inv), .fire_o(fire)
  );

  padevt_route #(.NUM_DEST(NUM_DEST)) u_route (
    .clk(clk), .rst_n(rst_n), .fire_i(fire), .route_i(cfg.route), .dest_o(dest)
  );

  assign pad_tx_o     = cfg.tx_val;
  assign evt_nmi_o    = dest[0];
  assign evt_smm_o    = dest[1];
  assign evt_sysctl_o = dest[2];
  assign evt_intc_o   = dest[3];

  // R8: receive disable silences every destination
  p_rxdis_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.rx_dis |=> (dest == '0));
  // R6: trigger off silences every destination
  p_off_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.trig == TRIG_OFF) |=> (dest == '0));
  // R7: an active output always had its routing bit set
  p_route_subset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((dest & ~$past(cfg.route)) == '0));
endmodule

// File: tb/test_padevt_router.sv
`timescale 1ns/1ps
module test_padevt_router;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pad = 1'b0;
  logic        we = 1'b0;
  logic        addr = 1'b0;
  logic [31:0] wdata = '0;
  logic        tx;
  logic [31:0] rdata;
  logic        e_nmi, e_smm, e_sys, e_intc;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  padevt_router i_padevt_router (
    .clk(clk), .rst_n(rst_n), .pad_rx_i(pad), .pad_tx_o(tx),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .evt_nmi_o(e_nmi), .evt_smm_o(e_smm), .evt_sysctl_o(e_sys), .evt_intc_o(e_intc)
  );

  // behavioural reference model
  bit       m_s1, m_s2, m_prev, m_stat, m_tx, m_dis, m_inv;
  bit [1:0] m_trig = 2'd2;
  bit [3:0] m_route, m_out;

  always @(posedge clk or negedge rst_n) begin
    bit q, hit, fire;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_stat = 0; m_tx = 0; m_dis = 0; m_inv = 0;
      m_trig = 2'd2; m_route = 0; m_out = 0;
    end else begin
      q = m_s2 ^ m_inv;
      case (m_trig)
        2'd0:    hit = q;
        2'd1:    hit = q && !m_prev;
        2'd3:    hit = (q != m_prev);
        default: hit = 0;
      endcase
      fire  = hit && !m_dis;
      m_out = fire ? m_route : 4'h0;
      if (fire) m_stat = 1;
      else if (we && addr && wdata[0]) m_stat = 0;
      if (we && !addr) begin
        m_prev  = m_s2 ^ wdata[23];
        m_trig  = wdata[26:25];
        m_inv   = wdata[23];
        m_route = wdata[20:17];
        m_dis   = wdata[9];
        m_tx    = wdata[0];
      end else begin
        m_prev = q;
      end
      m_s2 = m_s1;
      m_s1 = pad;
    end
  end

  task automatic cmp(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_rd();
    logic [31:0] r = '0;
    if (!addr) begin
      r[0] = m_tx; r[1] = m_s2; r[9] = m_dis; r[20:17] = m_route;
      r[23] = m_inv; r[26:25] = m_trig;
    end else begin
      r[0] = m_stat;
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      cmp({28'h0, e_intc, e_sys, e_smm, e_nmi}, {28'h0, m_out}, "R3 R4 R5 R6 R7 R8 R10 dest");
      cmp(rdata, exp_rd(), "R2 R9 R11 readback");
      cmp({31'h0, tx}, {31'h0, m_tx}, "R11 tx");
    end
  end

  function automatic logic [31:0] mk(input int trig, input int inv, input int route,
                                     input int dis, input int txv);
    logic [31:0] w = '0;
    w[26:25] = trig[1:0]; w[23] = inv[0]; w[20:17] = route[3:0];
    w[9] = dis[0]; w[0] = txv[0];
    return w;
  endfunction

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic a, input logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    tick(1);
    we = 1'b0; wdata = '0; addr = 1'b0;
  endtask

  task automatic pulses(input int n, input int w);
    for (int i = 0; i < n; i++) begin
      pad = 1'b1; tick(w);
      pad = 1'b0; tick(w);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    tick(3);
    // R1: reset state
    cmp({28'h0, e_intc, e_sys, e_smm, e_nmi}, 32'h0, "R1 dest in reset");
    cmp(rdata, 32'h0400_0000, "R1 config in reset");
    cmp({31'h0, tx}, 32'h0, "R1 tx in reset");
    rst_n = 1'b1;
    tick(2);
    // R3 level, plain and inverted
    wr(1'b0, mk(0, 0, 15, 0, 1));
    pulses(3, 5);
    wr(1'b0, mk(0, 1, 5, 0, 0));
    pulses(2, 4);
    wr(1'b1, 32'h1);
    // R4 rising, then falling
    wr(1'b0, mk(1, 0, 3, 0, 0));
    pulses(3, 3);
    wr(1'b0, mk(1, 1, 12, 0, 1));
    pulses(3, 3);
    // R5 both edges, minimum spacing
    wr(1'b0, mk(3, 0, 8, 0, 0));
    pulses(4, 1);
    // R6 off
    wr(1'b1, 32'h1);
    wr(1'b0, mk(2, 0, 15, 0, 0));
    pulses(3, 2);
    // R8 disable, status stays clear
    wr(1'b0, mk(3, 0, 15, 1, 1));
    pulses(4, 1);
    addr = 1'b1; tick(2);
    // R10 polarity flip on a high pad
    wr(1'b0, mk(1, 1, 15, 0, 0));
    pad = 1'b1; tick(4);
    wr(1'b0, mk(1, 0, 15, 0, 0));
    tick(3);
    wr(1'b0, mk(3, 1, 15, 0, 0));
    addr = 1'b1; tick(3);
    // R9 clear colliding with events in level mode
    wr(1'b0, mk(0, 0, 2, 0, 0));
    tick(3);
    wr(1'b1, 32'h1);
    pad = 1'b0; tick(4);
    wr(1'b1, 32'h1);
    addr = 1'b1; tick(2);
    // random mix
    for (int c = 0; c < 3000; c++) begin
      if ($urandom_range(0, 3) == 0) pad = ~pad;
      addr = $urandom_range(0, 1);
      if ($urandom_range(0, 29) == 0) begin
        we = 1'b1; wdata = $urandom();
      end else if ($urandom_range(0, 19) == 0) begin
        we = 1'b1; addr = 1'b1; wdata = $urandom();
      end else begin
        we = 1'b0;
      end
      tick(1);
    end
    we = 1'b0;
    tick(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule